// File: doc/BRIEF.md
# Telecom Add Bus Output Controller

This block drives the byte-wide add side of a SONET/SDH telecom bus. On every rising edge of the add clock it registers the outgoing data byte, an odd parity bit and the active-low add strobe. It also produces one output-enable per three-state signal. The pad drivers are not modelled, so high impedance appears as a deasserted enable.

Three timing sources can be selected. In add timing and drop timing, the payload-envelope flag and the combined C1/J1 marker arrive as inputs. In external timing, an internal frame counter generates both markers, and the block may drive them onto the bus. In that source the parity bit also covers the two generated markers. To prevent bus contention at power-up, the add strobe stays inactive after reset or after a clock-loss event until two C1 markers have been seen.

Top module: `add_bus_ctl`

## Requirements
- R1: In add timing (`mode`=0) and drop timing (`mode`=1), `par_out` is the odd parity bit of `data_out`. Odd parity means the count of ones in `{data_out, par_out}` is odd.
- R2: In external timing (`mode`=2), `par_out` makes the count of ones in `{data_out, spe_out, c1j1_out, par_out}` odd.
- R3: `par_oe` is high only when `tri_ctl` is 0 and `add_n` is low.
- R4: `spe_oe` and `c1j1_oe` are high only when `mode`=2, `ext_clk_en`=1 and `tri_ctl`=0. They are therefore low in drop timing.
- R5: The generated timing repeats every FRAME_LEN cycles. Counting from the first cycle after reset, `c1j1_out` is high for one cycle at frame position 0 (C1) and for one cycle at position J1_POS (J1). `spe_out` is high at positions SPE_START and above.
- R6: `add_n` goes high one edge after any of these is sampled at a clock edge: `rst`, `data_valid`=0, `clk_lost`=1 or `tri_ctl`=1.
- R7: After reset, `add_n` stays high until two C1 markers have been sampled. In add or drop timing, a C1 marker is a cycle with `c1j1_in`=1 and `spe_in`=0; a marker with `spe_in`=1 is J1 and is not counted. In external timing, the marker is the generated position 0.
- R8: `add_n_oe` follows `tri_n`, so the strobe floats while `tri_n` is low.
- R9: `data_out` is `data_in` as sampled at the previous clock edge, and `data_oe` is high exactly when `add_n` is low.
- R10: A cycle with `clk_lost`=1 clears the C1 count, so two fresh C1 markers are needed again before `add_n` can go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Add clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Timing source: 0 add, 1 drop, 2 external |
| tri_ctl | input | 1 | Three-state control bit |
| ext_clk_en | input | 1 | Lets external timing drive the markers |
| tri_n | input | 1 | Global float, active low |
| clk_lost | input | 1 | Add clock loss flag |
| data_valid | input | 1 | Payload byte present |
| data_in | input | DATA_W | Payload byte |
| spe_in | input | 1 | Incoming payload-envelope flag |
| c1j1_in | input | 1 | Incoming C1/J1 marker |
| data_out | output | DATA_W | Registered bus byte |
| data_oe | output | 1 | Data enable |
| par_out | output | 1 | Registered odd parity |
| par_oe | output | 1 | Parity enable |
| add_n | output | 1 | Registered add strobe, active low |
| add_n_oe | output | 1 | Strobe enable |
| spe_out | output | 1 | Generated envelope flag |
| spe_oe | output | 1 | Envelope flag enable |
| c1j1_out | output | 1 | Generated C1/J1 marker |
| c1j1_oe | output | 1 | Marker enable |

## Verification
The registered results (`data_out`, `par_out`, `add_n`, `spe_out`, `c1j1_out`) appear one edge after their inputs are sampled. A C1 marker counted at one edge therefore allows `add_n` to fall at the following edge at the earliest. The output enables follow the inputs and `add_n` with no added delay. The bench drives inputs on the falling edge and updates a behavioural model on the rising edge. It compares every output against that model at the next falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/add_bus_pkg.sv
package add_bus_pkg;
  typedef enum logic [1:0] {
    TM_ADD  = 2'd0,
    TM_DROP = 2'd1,
    TM_EXT  = 2'd2,
    TM_RSV  = 2'd3
  } timing_mode_e;
endpackage

// File: rtl/add_bus_timing_gen.sv
module add_bus_timing_gen #(
  parameter int FRAME_LEN = 32,
  parameter int SPE_START = 4,
  parameter int J1_POS    = 6
) (
  input  logic clk,
  input  logic rst,
  output logic spe_nxt,
  output logic c1j1_nxt,
  output logic c1_nxt,
  output logic spe_q,
  output logic c1j1_q
);
  localparam int FC_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam logic [FC_W-1:0] LAST = FC_W'(FRAME_LEN - 1);

  logic [FC_W-1:0] pos;

  always_comb begin
    c1_nxt   = (pos == '0);
    spe_nxt  = (pos >= FC_W'(SPE_START));
    c1j1_nxt = c1_nxt || (pos == FC_W'(J1_POS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos    <= '0;
      spe_q  <= 1'b0;
      c1j1_q <= 1'b0;
    end else begin
      pos    <= (pos == LAST) ? '0 : pos + 1'b1;
      spe_q  <= spe_nxt;
      c1j1_q <= c1j1_nxt;
    end
  end

  // R5: each marker lasts a single cycle
  a_r5_marker_one_wide: assert property (@(posedge clk) disable iff (rst)
    c1j1_q |=> !c1j1_q);
  // R5: the envelope flag is never raised out of the frame order
  a_r5_spe_after_start: assert property (@(posedge clk) disable iff (rst)
    $rose(spe_q) |-> !c1j1_q || (SPE_START == J1_POS));
endmodule

// File: rtl/add_bus_startup_guard.sv
module add_bus_startup_guard #(
  parameter int NEED = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic c1_seen,
  output logic armed
);
  localparam int CW = $clog2(NEED + 1);
  localparam logic [CW-1:0] FULL = CW'(NEED);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (c1_seen && cnt != FULL)
      cnt <= cnt + 1'b1;
  end

  assign armed = (cnt == FULL);

  // R7: the count never passes its limit
  a_r7_count_saturates: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);
  // R10: clock loss disarms the guard
  a_r10_loss_disarms: assert property (@(posedge clk) disable iff (rst)
    clr |=> !armed);
endmodule

// File: rtl/add_bus_parity.sv
module add_bus_parity #(
  parameter int WIDTH = 10
) (
  input  logic [WIDTH-1:0] bits,
  output logic             par
);
  logic [WIDTH:0] chain;

  assign chain[0] = 1'b1;
  for (genvar i = 0; i < WIDTH; i++) begin : g_x
    assign chain[i+1] = chain[i] ^ bits[i];
  end
  assign par = chain[WIDTH];
endmodule

// File: rtl/add_bus_ctl.sv
module add_bus_ctl
  import add_bus_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int FRAME_LEN = 32,
  parameter int SPE_START = 4,
  parameter int J1_POS    = 6,
  parameter int C1_NEED   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              tri_ctl,
  input  logic              ext_clk_en,
  input  logic              tri_n,
  input  logic              clk_lost,
  input  logic              data_valid,
  input  logic [DATA_W-1:0] data_in,
  input  logic              spe_in,
  input  logic              c1j1_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              par_out,
  output logic              par_oe,
  output logic              add_n,
  output logic              add_n_oe,
  output logic              spe_out,
  output logic              spe_oe,
  output logic              c1j1_out,
  output logic              c1j1_oe
);
  localparam int PW = DATA_W + 2;

  timing_mode_e tm;
  logic ext_sel, ext_q;
  logic spe_nxt, c1j1_nxt, c1_gen;
  logic c1_seen, armed, par_nxt;
  logic [PW-1:0] par_bits;

  assign tm      = timing_mode_e'(mode);
  assign ext_sel = (tm == TM_EXT);

  add_bus_timing_gen #(
    .FRAME_LEN(FRAME_LEN), .SPE_START(SPE_START), .J1_POS(J1_POS)
  ) u_tgen (
    .clk(clk), .rst(rst),
    .spe_nxt(spe_nxt), .c1j1_nxt(c1j1_nxt), .c1_nxt(c1_gen),
    .spe_q(spe_out), .c1j1_q(c1j1_out)
  );

  assign c1_seen = ext_sel ? c1_gen : (c1j1_in && !spe_in);

  add_bus_startup_guard #(.NEED(C1_NEED)) u_guard (
    .clk(clk), .rst(rst), .clr(clk_lost), .c1_seen(c1_seen), .armed(armed)
  );

  assign par_bits = {data_in, ext_sel && spe_nxt, ext_sel && c1j1_nxt};

  add_bus_parity #(.WIDTH(PW)) u_par (.bits(par_bits), .par(par_nxt));

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out <= '0;
      par_out  <= 1'b1;
      add_n    <= 1'b1;
      ext_q    <= 1'b0;
    end else begin
      data_out <= data_in;
      par_out  <= par_nxt;
      ext_q    <= ext_sel;
      add_n    <= !(data_valid && armed && !tri_ctl && !clk_lost);
    end
  end

  assign data_oe  = !add_n;
  assign par_oe   = !tri_ctl && !add_n;
  assign add_n_oe = tri_n;
  assign spe_oe   = ext_sel && ext_clk_en && !tri_ctl;
  assign c1j1_oe  = spe_oe;

  // R1 and R2: the registered byte, markers and parity bit hold an odd count of ones
  a_r2_odd_parity: assert property (@(posedge clk) disable iff (rst)
    ^{data_out, par_out, ext_q && spe_out, ext_q && c1j1_out} == 1'b1);
  // R6: the strobe is released after a blocking condition
  a_r6_block_releases: assert property (@(posedge clk) disable iff (rst)
    (tri_ctl || clk_lost || !data_valid) |=> add_n);
  // R7: a disarmed guard keeps the strobe high
  a_r7_guard_holds: assert property (@(posedge clk) disable iff (rst)
    !armed |=> add_n);
  // R3: parity never drives while the strobe is idle
  a_r3_par_float: assert property (@(posedge clk) disable iff (rst)
    add_n |-> !par_oe);
  // R4: drop timing never drives the markers
  a_r4_drop_float: assert property (@(posedge clk) disable iff (rst)
    (tm == TM_DROP) |-> !spe_oe && !c1j1_oe);
endmodule

// File: tb/add_bus_ctl_test.sv
module add_bus_ctl_test;
  localparam int DW = 8;
  localparam int FL = 32;
  localparam int SS = 4;
  localparam int JP = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic tri_ctl = 1'b0, ext_clk_en = 1'b0, tri_n = 1'b1, clk_lost = 1'b0;
  logic data_valid = 1'b0, spe_in = 1'b0, c1j1_in = 1'b0;
  logic [DW-1:0] data_in = '0;
  logic [DW-1:0] data_out;
  logic data_oe, par_out, par_oe, add_n, add_n_oe, spe_out, spe_oe, c1j1_out, c1j1_oe;

  add_bus_ctl uut (
    .clk(clk), .rst(rst), .mode(mode), .tri_ctl(tri_ctl), .ext_clk_en(ext_clk_en),
    .tri_n(tri_n), .clk_lost(clk_lost), .data_valid(data_valid), .data_in(data_in),
    .spe_in(spe_in), .c1j1_in(c1j1_in), .data_out(data_out), .data_oe(data_oe),
    .par_out(par_out), .par_oe(par_oe), .add_n(add_n), .add_n_oe(add_n_oe),
    .spe_out(spe_out), .spe_oe(spe_oe), .c1j1_out(c1j1_out), .c1j1_oe(c1j1_oe)
  );

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  int m_cnt = 0, m_pos = 0;
  logic [DW-1:0] e_data = '0;
  logic e_par = 1'b1, e_add_n = 1'b1, e_spe = 1'b0, e_c1j1 = 1'b0;
  bit done = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model of the registered outputs
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_pos = 0;
      e_data = '0; e_par = 1'b1; e_add_n = 1'b1; e_spe = 1'b0; e_c1j1 = 1'b0;
    end else begin
      bit ext, nspe, nmk, c1;
      int ones;
      ext  = (mode == 2'd2);
      nspe = (m_pos >= SS);
      nmk  = (m_pos == 0) || (m_pos == JP);
      c1   = ext ? (m_pos == 0) : (c1j1_in && !spe_in);
      e_add_n = !(data_valid && m_cnt >= 2 && !tri_ctl && !clk_lost);
      e_data = data_in;
      ones = 0;
      for (int i = 0; i < DW; i++) ones += data_in[i];
      if (ext) ones += nspe + nmk;
      e_par = (ones % 2 == 0);
      e_spe = nspe; e_c1j1 = nmk;
      m_pos = (m_pos + 1) % FL;
      if (clk_lost) m_cnt = 0;
      else if (c1 && m_cnt < 2) m_cnt++;
    end
  end

  // Compare all outputs away from the active edge
  always @(negedge clk) if (!done) begin
    check(mode == 2'd2 ? "R2 parity" : "R1 parity", par_out, e_par);
    check("R9 data", data_out, e_data);
    check("R9 data_oe", data_oe, !e_add_n);
    check("R6 add_n", add_n, e_add_n);
    check("R3 par_oe", par_oe, !tri_ctl && !e_add_n);
    check("R4 spe_oe", spe_oe, mode == 2'd2 && ext_clk_en && !tri_ctl);
    check("R4 c1j1_oe", c1j1_oe, mode == 2'd2 && ext_clk_en && !tri_ctl);
    check("R5 spe", spe_out, e_spe);
    check("R5 c1j1", c1j1_out, e_c1j1);
    check("R8 add_n_oe", add_n_oe, tri_n);
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      data_in = data_in * 8'd5 + 8'd3;
    end
  endtask

  task automatic pulse(bit is_c1);
    @(negedge clk);
    c1j1_in = 1'b1; spe_in = !is_c1;
    @(negedge clk);
    c1j1_in = 1'b0; spe_in = 1'b0;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    check("R6 reset add_n", add_n, 1'b1);
    check("R1 reset parity", par_out, 1'b1);
    rst = 1'b0; data_valid = 1'b1;
    step(4);
    check("R7 no C1 yet", add_n, 1'b1);
    pulse(1'b1);
    step(2);
    check("R7 one C1 only", add_n, 1'b1);
    pulse(1'b0);
    step(2);
    check("R7 J1 not counted", add_n, 1'b1);
    pulse(1'b1);
    step(1);
    check("R7 two C1 armed", add_n, 1'b0);
    step(10);
    data_valid = 1'b0; step(2);
    check("R6 no data", add_n, 1'b1);
    data_valid = 1'b1; tri_ctl = 1'b1; step(2);
    check("R6 tri_ctl", add_n, 1'b1);
    tri_ctl = 1'b0; step(2);
    check("R6 released", add_n, 1'b0);
    clk_lost = 1'b1; step(1); clk_lost = 1'b0; step(3);
    check("R10 rearm needed", add_n, 1'b1);
    mode = 2'd1;
    pulse(1'b1); pulse(1'b1); step(3);
    check("R10 drop rearmed", add_n, 1'b0);
    tri_n = 1'b0; step(2);
    check("R8 float", add_n_oe, 1'b0);
    tri_n = 1'b1;
    mode = 2'd2; ext_clk_en = 1'b1;
    step(80);
    ext_clk_en = 1'b0; step(5);
    rst = 1'b1; step(2); rst = 1'b0;
    step(70);
    tri_ctl = 1'b1; step(4); tri_ctl = 1'b0;
    mode = 2'd0; step(10);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule